// File: doc/BRIEF.md
# Memory Self-Check Engine

This block is a command-driven engine that verifies a region of memory starting at word address zero. Software programs a byte count and a 32-bit seed through a small configuration write port, then writes an 8-bit command code. Four checks exist. Two are read-only integrity checks: a 32-bit additive checksum and a reflected CRC-32. Two are destructive RAM tests: an address-pattern write/read test and a six-element March-C test.

The engine drives a single-port memory through a request/acknowledge handshake and handles one access at a time. Progress is visible as a fixed 16-bit state code. When a run ends, the engine shows a result word, pass and fail flags, and the word address of the first mismatch. A stop code aborts a run at the next access boundary. Any code outside the defined set raises a sticky error flag and starts nothing.

Top module: `mem_check_engine`

## Requirements
- R1: During reset `state_o` is 0x0000 (init) and `pass_o`, `fail_o` and `err_o` are 0. On the first clock edge after reset is released, `state_o` becomes 0x0001 (idle).
- R2: A command write carries the code in `cfg_wdata_i[7:0]`. The codes are 0x02 for the write/read test, 0x03 for March-C, 0x04 for checksum and 0x05 for CRC. Accepted in idle, each code sets `state_o` to the same value on the next edge. Codes 0x00 and 0x01 have no effect.
- R3: A command write whose code lies in 0x06..0xFE, or whose bits 15:8 are not zero, sets `err_o` on the next edge and starts nothing. Any later command write without such a code clears `err_o`.
- R4: Checksum: `result_o` equals the seed plus the sum, modulo 2^32, of the words at addresses 0..N-1, where N = size/4 rounded down. `pass_o` is set at the end.
- R5: CRC: the engine runs a reflected CRC-32 with polynomial 0x04C11DB7 (right-shift constant 0xEDB88320). The register starts at the seed and takes each word LSB first, with no final inversion. The value is placed in `result_o`.
- R6: Write/read test: the engine writes word i with `i ^ 0xA5A55A5A` for all N words in ascending order. It then reads them back in ascending order. The first mismatch sets `fail_o`, places the address in `fail_addr_o` and ends the run. A clean pass sets `pass_o`.
- R7: March-C uses a zero of 0x00000000 and a one of 0xFFFFFFFF. The six elements run in this order:
  - up: write zero;
  - up: read zero, write one;
  - up: read one, write zero;
  - down: read zero, write one;
  - down: read one, write zero;
  - up: read zero.

  The first mismatch sets `fail_o` and `fail_addr_o` and ends the run. A clean run sets `pass_o`.
- R8: Command 0xFF during a run returns the engine to idle on the edge that completes the access in flight, or the next one. Both `pass_o` and `fail_o` are then 0. In idle, 0xFF has no effect.
- R9: Command, size and seed writes made during a run do not affect that run's sequence or result.
- R10: A start with N = 0 (size below 4) makes no memory access and leaves `state_o` at idle. On the next edge it sets `pass_o` and sets `result_o` to the seed.
- R11: The engine holds `mem_req_o` and its address, write enable and write data stable until `mem_ack_i`. It never requests in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 size, 1 seed, 2 command |
| cfg_wdata_i | input | 32 | Configuration write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access completes this cycle |
| state_o | output | 16 | State code |
| result_o | output | 32 | Checksum or CRC result |
| pass_o | output | 1 | Last run completed clean |
| fail_o | output | 1 | Last run found a mismatch |
| fail_addr_o | output | AW | Word address of first mismatch |
| err_o | output | 1 | Last command write was illegal |

## Verification
The bench injects stuck-at-one and stuck-at-zero bits at a chosen word. The first fault shows up in the second March element and the second in the third. A design with wrong data polarity or wrong element order would report the wrong address or a pass. The bench varies memory latency and aborts a long run with the stop code, so a design that drops the stop or finishes the run anyway fails the bounded-idle check. It also writes start, size and seed during a run, and uses sizes of 0 and 3 and sizes that are not a multiple of 4. These catch designs that restart, re-read the live size, or access memory when the word count is zero. Reserved-bit and out-of-range codes confirm that the error flag sets without starting a run.

// File: rtl/mce_pkg.sv
package mce_pkg;
  typedef enum logic [15:0] {
    ST_INIT  = 16'h0000,
    ST_IDLE  = 16'h0001,
    ST_RW    = 16'h0002,
    ST_MARCH = 16'h0003,
    ST_CSUM  = 16'h0004,
    ST_CRC   = 16'h0005
  } mce_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_RW, OP_MARCH, OP_CSUM, OP_CRC, OP_STOP, OP_BAD
  } mce_op_e;

  localparam logic [1:0]  REG_SIZE = 2'd0;
  localparam logic [1:0]  REG_SEED = 2'd1;
  localparam logic [1:0]  REG_CMD  = 2'd2;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] RW_KEY        = 32'hA5A5_5A5A;
  localparam logic [31:0] PAT_ZERO      = 32'h0000_0000;
  localparam logic [31:0] PAT_ONE       = 32'hFFFF_FFFF;
endpackage

// File: rtl/mce_cmd_decode.sv
module mce_cmd_decode
  import mce_pkg::*;
(
  input  logic [15:0] cmd_i,
  output mce_op_e     op_o
);
  always_comb begin
    if (cmd_i[15:8] != 8'h00) op_o = OP_BAD;
    else begin
      unique case (cmd_i[7:0])
        8'h00, 8'h01: op_o = OP_NONE;
        8'h02:        op_o = OP_RW;
        8'h03:        op_o = OP_MARCH;
        8'h04:        op_o = OP_CSUM;
        8'h05:        op_o = OP_CRC;
        8'hFF:        op_o = OP_STOP;
        default:      op_o = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/mce_regs.sv
module mce_regs
  import mce_pkg::*;
#(
  parameter int DW = 32,
  localparam int NW = DW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  mce_op_e       op_i,
  output logic          cmd_go_o,
  output logic [NW-1:0] nwords_o,
  output logic [DW-1:0] seed_o,
  output logic          err_o
);
  assign cmd_go_o = cfg_we_i && (cfg_addr_i == REG_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nwords_o <= '0;
      seed_o   <= '0;
      err_o    <= 1'b0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        REG_SIZE: nwords_o <= cfg_wdata_i[DW-1:2];  // byte count -> words
        REG_SEED: seed_o   <= cfg_wdata_i;
        REG_CMD:  err_o    <= (op_i == OP_BAD);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mce_crc_word.sv
module mce_crc_word
  import mce_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] crc_o
);
  logic [DW-1:0] c;
  always_comb begin
    c = crc_i ^ data_i;
    for (int b = 0; b < DW; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL[DW-1:0]) : (c >> 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/mce_seq.sv
module mce_seq
  import mce_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int NW = DW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_go_i,
  input  mce_op_e       op_i,
  input  logic [NW-1:0] nwords_i,
  input  logic [DW-1:0] seed_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic [15:0]   state_o,
  output logic [DW-1:0] result_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  mce_state_e    state_q, mode;
  logic [NW-1:0] idx_q, last_q, word_idx;
  logic [2:0]    elem_q, last_elem;
  logic          sub_q, stop_q;
  logic [DW-1:0] acc_q, crc_nx, pat, wval, expv;
  logic          busy, desc, is_wr, two_ops, start_req, stop_req, miscmp;

  assign busy = (state_q != ST_INIT) && (state_q != ST_IDLE);
  assign desc = (state_q == ST_MARCH) && ((elem_q == 3'd3) || (elem_q == 3'd4));
  assign word_idx = desc ? (last_q - idx_q) : idx_q;
  assign pat = {{(DW-NW){1'b0}}, word_idx} ^ RW_KEY[DW-1:0];

  always_comb begin
    unique case (op_i)
      OP_RW:    mode = ST_RW;
      OP_MARCH: mode = ST_MARCH;
      OP_CSUM:  mode = ST_CSUM;
      OP_CRC:   mode = ST_CRC;
      default:  mode = ST_IDLE;
    endcase
  end

  assign start_req = cmd_go_i && (mode != ST_IDLE);
  assign stop_req  = cmd_go_i && (op_i == OP_STOP);

  // per-access operation
  always_comb begin
    is_wr = 1'b0; two_ops = 1'b0; wval = '0; expv = '0; last_elem = 3'd0;
    unique case (state_q)
      ST_RW: begin
        is_wr = (elem_q == 3'd0); wval = pat; expv = pat; last_elem = 3'd1;
      end
      ST_MARCH: begin
        last_elem = 3'd5;
        unique case (elem_q)
          3'd0: begin is_wr = 1'b1; wval = PAT_ZERO; end
          3'd1, 3'd3: begin
            two_ops = 1'b1; is_wr = sub_q; wval = PAT_ONE; expv = PAT_ZERO;
          end
          3'd2, 3'd4: begin
            two_ops = 1'b1; is_wr = sub_q; wval = PAT_ZERO; expv = PAT_ONE;
          end
          default: expv = PAT_ZERO;
        endcase
      end
      default: ;
    endcase
  end

  assign miscmp = !is_wr && ((state_q == ST_RW) || (state_q == ST_MARCH))
                  && (mem_rdata_i != expv);

  mce_crc_word #(.DW(DW)) u_crc (.crc_i(acc_q), .data_i(mem_rdata_i), .crc_o(crc_nx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT; idx_q <= '0; last_q <= '0; elem_q <= '0;
      sub_q <= 1'b0; stop_q <= 1'b0; acc_q <= '0;
      pass_o <= 1'b0; fail_o <= 1'b0; fail_addr_o <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: state_q <= ST_IDLE;
        ST_IDLE: begin
          if (start_req) begin
            pass_o <= 1'b0; fail_o <= 1'b0; fail_addr_o <= '0;
            acc_q <= seed_i; idx_q <= '0; elem_q <= '0; sub_q <= 1'b0;
            stop_q <= 1'b0; last_q <= nwords_i - 1'b1;
            if (nwords_i == '0) pass_o <= 1'b1;
            else state_q <= mode;
          end
        end
        default: begin
          if (mem_ack_i) begin
            if (stop_q || stop_req) begin
              state_q <= ST_IDLE; stop_q <= 1'b0;
            end else if (miscmp) begin
              fail_o <= 1'b1; fail_addr_o <= mem_addr_o; state_q <= ST_IDLE;
            end else begin
              if (state_q == ST_CSUM) acc_q <= acc_q + mem_rdata_i;
              if (state_q == ST_CRC)  acc_q <= crc_nx;
              if (two_ops && !sub_q) sub_q <= 1'b1;
              else begin
                sub_q <= 1'b0;
                if (idx_q == last_q) begin
                  idx_q <= '0;
                  if (elem_q == last_elem) begin
                    state_q <= ST_IDLE; pass_o <= 1'b1;
                  end else elem_q <= elem_q + 3'd1;
                end else idx_q <= idx_q + 1'b1;
              end
            end
          end else if (stop_req) stop_q <= 1'b1;
        end
      endcase
    end
  end

  assign mem_req_o   = busy;
  assign mem_we_o    = busy && is_wr;
  assign mem_addr_o  = word_idx[AW-1:0];
  assign mem_wdata_o = wval;
  assign state_o     = state_q;
  assign result_o    = acc_q;
endmodule

// File: rtl/mem_check_engine.sv
module mem_check_engine
  import mce_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic [15:0]   state_o,
  output logic [31:0]   result_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic          err_o
);
  localparam int NW = DW - 2;

  mce_op_e       op;
  logic          cmd_go;
  logic [NW-1:0] nwords;
  logic [DW-1:0] seed;

  mce_cmd_decode u_dec (.cmd_i(cfg_wdata_i[15:0]), .op_o(op));

  mce_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .op_i(op), .cmd_go_o(cmd_go), .nwords_o(nwords), .seed_o(seed), .err_o
  );

  mce_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni, .cmd_go_i(cmd_go), .op_i(op), .nwords_i(nwords), .seed_i(seed),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i,
    .state_o, .result_o, .pass_o, .fail_o, .fail_addr_o
  );
endmodule

// File: rtl/mce_checker.sv
module mce_checker #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_addr_i,
  input logic [31:0]   cfg_wdata_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic [15:0]   state_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic          err_o
);
  logic cmd_wr, bad_code, stop_code;
  assign cmd_wr    = cfg_we_i && (cfg_addr_i == 2'd2);
  assign bad_code  = (cfg_wdata_i[15:8] != 8'h00) ||
                     ((cfg_wdata_i[7:0] >= 8'h06) && (cfg_wdata_i[7:0] <= 8'hFE));
  assign stop_code = (cfg_wdata_i[15:0] == 16'h00FF);

  a_r1_leave_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 16'h0000 |=> state_o == 16'h0001);

  a_r2_state_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 16'h0005);

  a_r3_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && bad_code |=> err_o);

  a_r7_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  a_r8_stop_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && stop_code && mem_req_o && mem_ack_i
    |=> state_o == 16'h0001 && !pass_o && !fail_o);

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i
    |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 16'h0001 |-> !mem_req_o);
endmodule

bind mem_check_engine mce_checker #(.AW(AW)) u_mce_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .state_o(state_o), .pass_o(pass_o), .fail_o(fail_o), .err_o(err_o)
);

// File: tb/mem_check_engine_bench.sv
module mem_check_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MW = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [31:0] mem_wdata, mem_rdata, result;
  logic [15:0] state;
  logic pass, fail, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_check_engine u_mem_check_engine (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .state_o(state), .result_o(result),
    .pass_o(pass), .fail_o(fail), .fail_addr_o(fail_addr), .err_o(err)
  );

  // memory model with programmable latency and one faulty word
  logic [31:0] mem [MW];
  int lat = 0;
  int wcnt = 0;
  int fault_idx = -1;
  logic [31:0] f_or = '0, f_and = '1;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack <= 1'b0; mem_rdata <= '0; wcnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          wcnt <= 0; mem_ack <= 1'b1;
          if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
          else if (int'(mem_addr[7:0]) == fault_idx) mem_rdata <= (mem[mem_addr[7:0]] | f_or) & f_and;
          else mem_rdata <= mem[mem_addr[7:0]];
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    string       r;
    bit          chk_res;
    logic [31:0] res;
    logic        pass;
    logic        fail;
    logic [AW-1:0] faddr;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.r, "pass", 32'(pass), 32'(e.pass));
        chk(e.r, "fail", 32'(fail), 32'(e.fail));
        if (e.fail) chk(e.r, "fail_addr", 32'(fail_addr), 32'(e.faddr));
        if (e.chk_res) chk(e.r, "result", result, e.res);
        chk(e.r, "state idle", 32'(state), 32'h1);
      end
    end
  end

  task automatic push(input string r, input bit cr, input logic [31:0] res,
                      input logic p, input logic f, input logic [AW-1:0] fa);
    exp_t e;
    e.r = r; e.chk_res = cr; e.res = res; e.pass = p; e.fail = f; e.faddr = fa;
    exp_q.push_back(e);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(input string r);
    int n = 0;
    while (state != 16'h1 && n < 20000) begin
      @(negedge clk); n++;
    end
    if (n >= 20000) begin
      checks++; errors++;
      $display("FAIL %s run timeout actual=%h expected=0001", r, state);
    end
  endtask

  function automatic logic [31:0] fword(input int i, input logic [31:0] key);
    return (32'(i) * 32'h0100_0193) ^ key;
  endfunction

  task automatic fill(input int n, input logic [31:0] key);
    for (int i = 0; i < n; i++) mem[i] = fword(i, key);
  endtask

  function automatic logic [31:0] ref_sum(input int n, input logic [31:0] seed);
    logic [31:0] s = seed;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s;
  endfunction

  function automatic logic [31:0] ref_crc(input int n, input logic [31:0] seed);
    logic [31:0] c = seed;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 4; b++) begin
        c = c ^ {24'h0, mem[i][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    return c;
  endfunction

  // start a run, check the state code, wait for the end and score it
  task automatic run(input string r, input logic [7:0] code, input logic [15:0] st);
    cfg_write(2'd2, {24'h0, code});
    chk(r, "running state", 32'(state), 32'(st));
    wait_idle(r);
    -> chk_ev;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] e;
    int n;
    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1", "state in reset", 32'(state), 32'h0);
    chk("R1", "flags in reset", {29'h0, pass, fail, err}, 32'h0);
    rst_ni = 1'b1;
    #1 chk("R1", "state before first edge", 32'(state), 32'h0);
    @(negedge clk);
    chk("R1", "state after first edge", 32'(state), 32'h1);

    // R2 no-op codes, R11 no request in idle
    cfg_write(2'd2, 32'h0000_0000);
    chk("R2", "nop 00 state", 32'(state), 32'h1);
    cfg_write(2'd2, 32'h0000_0001);
    chk("R2", "nop 01 state", 32'(state), 32'h1);
    chk("R11", "idle request", 32'(mem_req), 32'h0);

    // R4 checksum
    fill(MW, 32'hDEAD_BEEF);
    cfg_write(2'd0, 32'd64); cfg_write(2'd1, 32'h0);
    push("R4", 1'b1, ref_sum(16, 32'h0), 1'b1, 1'b0, '0);
    run("R4", 8'h04, 16'h4);
    lat = 2;
    cfg_write(2'd0, 32'd66); cfg_write(2'd1, 32'h1234_5678);
    push("R4", 1'b1, ref_sum(16, 32'h1234_5678), 1'b1, 1'b0, '0);
    run("R4", 8'h04, 16'h4);

    // R5 CRC
    lat = 1;
    cfg_write(2'd0, 32'd40); cfg_write(2'd1, 32'hFFFF_FFFF);
    push("R5", 1'b1, ref_crc(10, 32'hFFFF_FFFF), 1'b1, 1'b0, '0);
    run("R5", 8'h05, 16'h5);
    lat = 0;
    cfg_write(2'd0, 32'd128); cfg_write(2'd1, 32'h0);
    push("R5", 1'b1, ref_crc(32, 32'h0), 1'b1, 1'b0, '0);
    run("R5", 8'h05, 16'h5);

    // R6 write/read test
    cfg_write(2'd0, 32'd256);
    push("R6", 1'b0, '0, 1'b1, 1'b0, '0);
    run("R6", 8'h02, 16'h2);
    chk("R6", "pattern word 0", mem[0], 32'hA5A5_5A5A);
    chk("R6", "pattern word 63", mem[63], 32'd63 ^ 32'hA5A5_5A5A);
    fault_idx = 6; f_or = 32'h1; f_and = '1;
    push("R6", 1'b0, '0, 1'b0, 1'b1, 16'd6);
    run("R6", 8'h02, 16'h2);

    // R7 March-C
    fault_idx = -1; f_or = '0; lat = 1;
    cfg_write(2'd0, 32'd128);
    push("R7", 1'b0, '0, 1'b1, 1'b0, '0);
    run("R7", 8'h03, 16'h3);
    chk("R7", "final contents", mem[31], 32'h0);
    fault_idx = 9; f_or = 32'h1; f_and = '1;
    push("R7", 1'b0, '0, 1'b0, 1'b1, 16'd9);
    run("R7", 8'h03, 16'h3);
    fault_idx = 20; f_or = '0; f_and = 32'hFFFF_FFFE;
    push("R7", 1'b0, '0, 1'b0, 1'b1, 16'd20);
    run("R7", 8'h03, 16'h3);
    fault_idx = -1; f_and = '1; lat = 0;

    // R3 illegal codes
    cfg_write(2'd2, 32'h0000_0006);
    chk("R3", "err after 06", 32'(err), 32'h1);
    chk("R3", "no start on 06", 32'(state), 32'h1);
    cfg_write(2'd2, 32'h0000_0001);
    chk("R3", "err cleared", 32'(err), 32'h0);
    cfg_write(2'd2, 32'h0000_00FE);
    chk("R3", "err after FE", 32'(err), 32'h1);
    cfg_write(2'd2, 32'h0000_0104);
    chk("R3", "err reserved bits", 32'(err), 32'h1);
    chk("R3", "no start reserved", {31'h0, mem_req}, 32'h0);
    cfg_write(2'd2, 32'h0000_0000);
    chk("R3", "err cleared again", 32'(err), 32'h0);

    // R8 stop
    fill(MW, 32'h0F0F_1234);
    lat = 2;
    cfg_write(2'd0, 32'd800); cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h0000_0004);
    repeat (10) @(negedge clk);
    cfg_write(2'd2, 32'h0000_00FF);
    n = 0;
    while (state != 16'h1 && n < 50) begin @(negedge clk); n++; end
    chk("R8", "cycles to idle ok", 32'(n <= 4), 32'h1);
    chk("R8", "verdict after stop", {30'h0, pass, fail}, 32'h0);
    cfg_write(2'd2, 32'h0000_00FF);
    chk("R8", "stop in idle state", 32'(state), 32'h1);
    chk("R8", "stop in idle err", 32'(err), 32'h0);

    // R9 writes during a run
    lat = 1;
    cfg_write(2'd0, 32'd400); cfg_write(2'd1, 32'h5555_0001);
    e = ref_sum(100, 32'h5555_0001);
    push("R9", 1'b1, e, 1'b1, 1'b0, '0);
    cfg_write(2'd2, 32'h0000_0004);
    repeat (3) @(negedge clk);
    cfg_write(2'd2, 32'h0000_0005);
    cfg_write(2'd0, 32'd0);
    cfg_write(2'd1, 32'h0000_FFFF);
    chk("R9", "state kept", 32'(state), 32'h4);
    wait_idle("R9");
    -> chk_ev;
    @(negedge clk);

    // R10 zero words
    lat = 0;
    cfg_write(2'd0, 32'd0); cfg_write(2'd1, 32'hCAFE_F00D);
    cfg_write(2'd2, 32'h0000_0005);
    chk("R10", "state stays idle", 32'(state), 32'h1);
    chk("R10", "pass", 32'(pass), 32'h1);
    chk("R10", "result is seed", result, 32'hCAFE_F00D);
    cfg_write(2'd0, 32'd3); cfg_write(2'd1, 32'h0BAD_0BAD);
    cfg_write(2'd2, 32'h0000_0003);
    chk("R10", "size 3 idle", {15'h0, state, mem_req}, {15'h0, 16'h1, 1'b0});
    chk("R10", "size 3 result", result, 32'h0BAD_0BAD);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule